// File: doc/BRIEF.md
# Debug-Aware Reset Configuration Controller

This block sits between the board-level reset pins and the chip's reset network. A mode strap selects between normal operation and emulator (debug) operation. Two active-low requests are watched: a system reset and a test-logic reset. From these the block drives three outputs. The first is the CPU reset. The second is the debug-logic reset. The third is a CPU run enable that lets the processor start fetching.

All three pins pass through two-flop synchronizers clocked by the system clock. Each output follows its synchronized input, so an output asserts as soon as the synchronized level changes and also releases on a clock edge.

In emulator mode the block adds a sticky reset hold. It is entered when both requests stay low together for a programmable number of clocks. While the hold is in effect, the CPU is kept from running even after the system reset is released. The debug logic can still be brought out of reset, so an external debugger can take control before the first instruction runs. The hold ends on any of these events:
- a fresh falling edge of the system reset,
- a fresh falling edge of the test reset,
- a switch of the strap to normal mode.

Top module: `rcfg_reset_ctrl`

## Requirements
- R1: `mode_sel_i` = 1 selects normal mode and 0 selects emulator mode. In normal mode the hold is never entered, however long both requests stay low.
- R2: In either mode, a low `sys_rst_n_i` drives `cpu_rst_n_o` and `cpu_run_o` low. A high `tst_rst_n_i` leaves `dbg_rst_n_o` high.
- R3: With `sys_rst_n_i` high and `tst_rst_n_i` low, and no hold in effect, only `dbg_rst_n_o` is low. `cpu_rst_n_o` and `cpu_run_o` stay high.
- R4: With both requests high and no hold in effect, all three outputs are high.
- R5: In emulator mode, both synchronized requests low for at least HOLD_CYCLES consecutive clocks enters the hold. A run of HOLD_CYCLES-1 clocks or shorter does not.
- R6: While the hold is in effect, `cpu_run_o` stays low. `cpu_rst_n_o` follows the system request and `dbg_rst_n_o` follows the test request.
- R7: A new falling edge of the system request, after it has been high, clears the hold. The outputs then follow R2 to R4.
- R8: A new falling edge of the test request, after it has been high, clears the hold.
- R9: Changing the strap to normal mode clears the hold.
- R10: While `por_n_i` is low, all three outputs are low. After `por_n_i` is released, a pin change reaches the outputs after exactly two rising clock edges.
- R11: Keeping both requests low after the hold has been entered does not clear the hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| por_n_i | input | 1 | Power-on reset for the block's own flops, active low |
| mode_sel_i | input | 1 | Mode strap: 1 = normal, 0 = emulator |
| sys_rst_n_i | input | 1 | System reset request, active low, asynchronous |
| tst_rst_n_i | input | 1 | Test-logic reset request, active low, asynchronous |
| cpu_rst_n_o | output | 1 | CPU reset, active low |
| dbg_rst_n_o | output | 1 | Debug-logic reset, active low |
| cpu_run_o | output | 1 | CPU run enable |

## Verification
All eight combinations of strap, system request and test request are applied starting from a no-hold state. Each combination is held for fewer clocks than the hold threshold, which separates the plain reset table from the hold behaviour. A sweep of both-low durations from one clock up to two clocks past the threshold finds the exact boundary of hold entry, checked in emulator mode and also in normal mode. Once the hold is in effect, the bench releases the requests one at a time and then clears the hold in each of three ways: system re-assertion, test re-assertion, and the strap switch. This shows that the run enable is decoupled from the CPU reset output and that each exit path works on its own.

// File: rtl/rcfg_pkg.sv
`timescale 1ns/1ps
package rcfg_pkg;
  // Next value of the both-low run counter: zero when the run breaks,
  // saturating at the limit so a long hold keeps the armed flag up.
  function automatic int unsigned hold_count_next(int unsigned cnt, logic both_low,
                                                  int unsigned limit);
    if (!both_low)    return 0;
    if (cnt >= limit) return limit;
    return cnt + 1;
  endfunction

  // Hold is armed once the run counter has reached the limit.
  function automatic logic hold_reached(int unsigned cnt, int unsigned limit);
    return cnt >= limit;
  endfunction
endpackage

// File: rtl/rcfg_sync.sv
`timescale 1ns/1ps
module rcfg_sync #(
  parameter int unsigned     W       = 3,
  parameter int unsigned     STAGES  = 2,
  parameter logic [W-1:0]    RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_n_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk_i or negedge rst_n_i) begin
          if (!rst_n_i) stg_q[0] <= RST_VAL;
          else          stg_q[0] <= d_i;
        end
      end else begin : g_next
        always_ff @(posedge clk_i or negedge rst_n_i) begin
          if (!rst_n_i) stg_q[s] <= RST_VAL;
          else          stg_q[s] <= stg_q[s-1];
        end
      end
    end
  endgenerate

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/rcfg_hold_ctrl.sv
`timescale 1ns/1ps
module rcfg_hold_ctrl
  import rcfg_pkg::*;
#(
  parameter int unsigned HOLD_CYCLES = 16,
  localparam int unsigned CW         = $clog2(HOLD_CYCLES + 1)
) (
  input  logic clk_i,
  input  logic rst_n_i,
  input  logic emu_i,
  input  logic sys_i,
  input  logic tst_i,
  output logic armed_o,
  output logic clr_o,
  output logic hold_o
);
  logic [CW-1:0] cnt_q;
  logic          sys_d_q, tst_d_q, hold_q;
  logic          both_low;

  assign both_low = emu_i & ~sys_i & ~tst_i;
  assign armed_o  = hold_reached(32'(cnt_q), HOLD_CYCLES);
  // Fresh falling edge of either request, or leaving emulator mode.
  assign clr_o    = (sys_d_q & ~sys_i) | (tst_d_q & ~tst_i) | ~emu_i;

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      cnt_q   <= '0;
      sys_d_q <= 1'b0;
      tst_d_q <= 1'b0;
      hold_q  <= 1'b0;
    end else begin
      cnt_q   <= CW'(hold_count_next(32'(cnt_q), both_low, HOLD_CYCLES));
      sys_d_q <= sys_i;
      tst_d_q <= tst_i;
      if (armed_o)    hold_q <= 1'b1;
      else if (clr_o) hold_q <= 1'b0;
    end
  end

  assign hold_o = hold_q;
endmodule

// File: rtl/rcfg_reset_ctrl.sv
`timescale 1ns/1ps
module rcfg_reset_ctrl #(
  parameter int unsigned HOLD_CYCLES = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic por_n_i,
  input  logic mode_sel_i,
  input  logic sys_rst_n_i,
  input  logic tst_rst_n_i,
  output logic cpu_rst_n_o,
  output logic dbg_rst_n_o,
  output logic cpu_run_o
);
  // Synchronized bits: [2] mode strap, [1] system request, [0] test request.
  localparam logic [2:0] SYNC_RST = 3'b100;

  logic [2:0] pins_s;
  logic       mode_s_w, sys_s_w, tst_s_w, emu_w;
  logic       armed_w, clr_w, hold_w;

  rcfg_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(SYNC_RST)) sync_i (
    .clk_i  (clk_i),
    .rst_n_i(por_n_i),
    .d_i    ({mode_sel_i, sys_rst_n_i, tst_rst_n_i}),
    .q_o    (pins_s)
  );

  assign mode_s_w = pins_s[2];
  assign sys_s_w  = pins_s[1];
  assign tst_s_w  = pins_s[0];
  assign emu_w    = ~mode_s_w;

  rcfg_hold_ctrl #(.HOLD_CYCLES(HOLD_CYCLES)) hold_i (
    .clk_i  (clk_i),
    .rst_n_i(por_n_i),
    .emu_i  (emu_w),
    .sys_i  (sys_s_w),
    .tst_i  (tst_s_w),
    .armed_o(armed_w),
    .clr_o  (clr_w),
    .hold_o (hold_w)
  );

  assign cpu_rst_n_o = sys_s_w;
  assign dbg_rst_n_o = tst_s_w;
  assign cpu_run_o   = sys_s_w & ~hold_w;
endmodule

// File: rtl/rcfg_reset_ctrl_chk.sv
`timescale 1ns/1ps
module rcfg_reset_ctrl_chk (
  input logic clk_i,
  input logic por_n_i,
  input logic emu_w,
  input logic armed_w,
  input logic clr_w,
  input logic hold_w,
  input logic cpu_rst_n_o,
  input logic cpu_run_o
);
  p_hold_enter_r5: assert property (@(posedge clk_i) disable iff (!por_n_i)
    armed_w |=> hold_w);

  p_hold_blocks_run_r6: assert property (@(posedge clk_i) disable iff (!por_n_i)
    hold_w |-> !cpu_run_o);

  p_hold_clear_r8: assert property (@(posedge clk_i) disable iff (!por_n_i)
    (clr_w && !armed_w) |=> !hold_w);

  p_normal_no_hold_r1: assert property (@(posedge clk_i) disable iff (!por_n_i)
    (!emu_w && $past(!emu_w)) |-> !hold_w);

  p_run_needs_release_r2: assert property (@(posedge clk_i) disable iff (!por_n_i)
    cpu_run_o |-> cpu_rst_n_o);

  p_free_run_r4: assert property (@(posedge clk_i) disable iff (!por_n_i)
    (cpu_rst_n_o && !hold_w) |-> cpu_run_o);

  p_hold_only_armed_r7: assert property (@(posedge clk_i) disable iff (!por_n_i)
    $rose(hold_w) |-> $past(armed_w));
endmodule

bind rcfg_reset_ctrl rcfg_reset_ctrl_chk chk_i (
  .clk_i      (clk_i),
  .por_n_i    (por_n_i),
  .emu_w      (emu_w),
  .armed_w    (armed_w),
  .clr_w      (clr_w),
  .hold_w     (hold_w),
  .cpu_rst_n_o(cpu_rst_n_o),
  .cpu_run_o  (cpu_run_o)
);

// File: tb/rcfg_reset_ctrl_tb.sv
`timescale 1ns/1ps
module rcfg_reset_ctrl_tb_top;
  localparam int unsigned N = 6;

  logic clk = 1'b0;
  logic por_n = 1'b0;
  logic mode = 1'b0, sys_n = 1'b0, tst_n = 1'b0;
  logic cpu_rst_n, dbg_rst_n, run;
  int   tests = 0, fails = 0;
  bit   done = 1'b0;

  always #5 clk = ~clk;

  rcfg_reset_ctrl #(.HOLD_CYCLES(N)) dut_i (
    .clk_i(clk), .por_n_i(por_n), .mode_sel_i(mode),
    .sys_rst_n_i(sys_n), .tst_rst_n_i(tst_n),
    .cpu_rst_n_o(cpu_rst_n), .dbg_rst_n_o(dbg_rst_n), .cpu_run_o(run)
  );

  // Expected outputs {cpu_rst_n, dbg_rst_n, run} from pin levels and hold.
  function automatic logic [2:0] expect_out(logic s, logic t, logic h);
    return {s, t, s & ~h};
  endfunction

  task automatic chk(string tag, logic [2:0] exp);
    tests++;
    if ({cpu_rst_n, dbg_rst_n, run} !== exp) begin
      fails++;
      $display("FAIL %s: got %b expected %b", tag, {cpu_rst_n, dbg_rst_n, run}, exp);
    end
  endtask

  task automatic pins(logic m, logic s, logic t);
    mode = m; sys_n = s; tst_n = t;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic enter_hold();
    pins(1'b0, 1'b1, 1'b1); idle(4);
    pins(1'b0, 1'b0, 1'b0); idle(N + 3);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    idle(5);
    chk("R10 outputs during power-on reset", 3'b000);
    pins(1'b1, 1'b1, 1'b1);
    @(negedge clk); por_n = 1'b1; idle(5);
    chk("R4 idle after power-on", 3'b111);

    // R10: two-edge latency on a system request assertion.
    pins(1'b1, 1'b0, 1'b1); idle(1);
    chk("R10 one edge after pin change", 3'b111);
    idle(1);
    chk("R10 two edges after pin change", 3'b010);
    pins(1'b1, 1'b1, 1'b1); idle(5);

    // R2/R3/R4: full table, short dwell (below hold threshold).
    for (int c = 0; c < 8; c++) begin
      logic m, s, t;
      {m, s, t} = 3'(c);
      pins(m, 1'b1, 1'b1); idle(4);
      pins(m, s, t); idle(4);
      if (!s)      chk("R2 table, system request low", expect_out(s, t, 1'b0));
      else if (!t) chk("R3 table, test request only", expect_out(s, t, 1'b0));
      else         chk("R4 table, both released", expect_out(s, t, 1'b0));
      pins(m, 1'b1, 1'b1); idle(4);
    end

    // R5 sweep in emulator mode, R1 sweep in normal mode; R8 exit.
    for (int l = 1; l <= int'(N) + 2; l++) begin
      for (int mm = 0; mm < 2; mm++) begin
        logic h;
        h = (mm == 0) && (l >= int'(N));
        pins(1'(mm), 1'b1, 1'b1); idle(4);
        pins(1'(mm), 1'b0, 1'b0); idle(l);
        pins(1'(mm), 1'b1, 1'b1); idle(5);
        if (mm == 0) chk($sformatf("R5 both low for %0d clocks", l), expect_out(1'b1, 1'b1, h));
        else         chk($sformatf("R1 normal mode, low for %0d clocks", l), expect_out(1'b1, 1'b1, 1'b0));
        if (h) begin
          pins(1'b0, 1'b1, 1'b0); idle(3);
          pins(1'b0, 1'b1, 1'b1); idle(5);
          chk("R8 test re-assert clears hold", 3'b111);
        end
      end
    end

    // R11 then R6 then R7.
    enter_hold(); idle(30);
    chk("R11 long both-low keeps reset", 3'b000);
    pins(1'b0, 1'b1, 1'b0); idle(5);
    chk("R6 system released, still held", expect_out(1'b1, 1'b0, 1'b1));
    pins(1'b0, 1'b1, 1'b1); idle(5);
    chk("R6 debug released, CPU still held", expect_out(1'b1, 1'b1, 1'b1));
    pins(1'b0, 1'b0, 1'b1); idle(3);
    chk("R7 system re-assert", 3'b010);
    pins(1'b0, 1'b1, 1'b1); idle(5);
    chk("R7 hold cleared by system re-assert", 3'b111);

    // R9: strap switch clears hold.
    enter_hold();
    pins(1'b0, 1'b1, 1'b1); idle(5);
    chk("R9 held before strap switch", 3'b110);
    pins(1'b1, 1'b1, 1'b1); idle(5);
    chk("R9 strap to normal clears hold", 3'b111);
    pins(1'b0, 1'b1, 1'b1); idle(5);
    chk("R9 back to emulator, no hold", 3'b111);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule